// File: doc/BRIEF.md
# Adaptation Spectral Gating Correlator

This block sits beside an equalizer adaptation engine and decides whether the recovered data is random enough for the adaptation updates to be trusted. It keeps a sliding window of recovered bits around the current decision, fourteen bits wide: the decision bit itself, ten older bits and three newer bits. On each snapshot strobe it compares the current decision with a chosen set of older bits. Each compared pair that agrees counts one up and each pair that disagrees counts one down, and the result is added to a saturating signed accumulator.

After a programmable number of snapshots (one evaluation window), the magnitude of the accumulated sum is compared with a threshold. If the magnitude is at or below the threshold the data is judged random and adaptation stays enabled. If it is above, the enable is dropped. Static or repetitive data builds a large magnitude and freezes the equalizer taps. Pseudo-random data keeps the sum near zero. A separate clear input restarts the current evaluation window.

The control has two named states. `ST_FILL` is entered at reset and waits until fourteen valid bits have filled the window. Transition `FILL->TRACK` happens on the clock edge that shifts in the fourteenth valid bit. `ST_TRACK` then holds until the next reset, accepting snapshots and closing a window every `EVAL_LEN` accepted snapshots.

Top module: `spectral_gate`

## Requirements
- R1: After reset `adapt_en` is 0, `acc_out` is 0 and the block is in `ST_FILL`.
- R2: Snapshot strobes are ignored until fourteen valid bits have been shifted in; this includes the edge that shifts in the fourteenth bit.
- R3: The window shifts left on each valid bit, with the newest bit at position 0, so the current decision d(n) is at position 3. Bit i of `lag_sel` (i = 0..9) pairs d(n) with the bit i+1 positions older (position 4+i). Each selected pair adds +1 to the snapshot sum if the two bits are equal and -1 if they differ.
- R4: A snapshot uses the window as it stood before a bit shifted in on the same edge.
- R5: The accumulator is a 9-bit two's-complement value that saturates at +255 and -256 and never wraps. Its magnitude at -256 is 256.
- R6: The accepted snapshot that completes `EVAL_LEN` snapshots sets `adapt_en` to 1 when the magnitude of the final saturated sum is no greater than `thresh`, and to 0 otherwise. On that same edge the accumulator and the snapshot count clear. `adapt_en` changes at no other time.
- R7: `acc_clr` clears the accumulator and the snapshot count. It wins over a snapshot on the same edge, and that edge leaves `adapt_en` unchanged.
- R8: Static data with all lags selected drops `adapt_en` at the window end. Pseudo-random data with a threshold of 100 leaves it at 1.
- R9: A bit presented while `bit_valid` is low is not shifted in and does not count toward the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Recovered data bit |
| bit_valid | input | 1 | Shifts `bit_in` into the window |
| snap_en | input | 1 | Snapshot strobe: correlates the current window |
| acc_clr | input | 1 | Restarts the evaluation window |
| lag_sel | input | 10 | Lag selection mask, bit i selects lag i+1 |
| thresh | input | 9 | Largest magnitude that keeps adaptation enabled |
| adapt_en | output | 1 | Adaptation allowed |
| acc_out | output | 9 | Accumulator, two's complement |

## Verification
Two collisions matter here. The first is a clear arriving on the same edge as the snapshot that would close the window. The bench streams 63 snapshots and then raises `acc_clr` and `snap_en` together; it expects a zero accumulator and an enable that has not moved. The second is a snapshot coinciding with a bit shift. The exhaustive sweep over all 1024 lag masks always shifts and snapshots on the same edge, and a window model in the bench, updated after the correlation, decides the expected sum.

// File: rtl/spgate_pkg.sv
`timescale 1ns/1ps
package spgate_pkg;
    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_TRACK = 1'b1
    } gate_state_e;
endpackage

// File: rtl/spg_snap_window.sv
`timescale 1ns/1ps
module spg_snap_window #(
    parameter int PAST_BITS   = 10,
    parameter int FUTURE_BITS = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             shift_en,
    input  logic                             bit_in,
    output logic [PAST_BITS+FUTURE_BITS:0]   win
);
    localparam int WIN_LEN = PAST_BITS + FUTURE_BITS + 1;

    // newest bit enters at position 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win <= '0;
        else if (shift_en)
            win <= {win[WIN_LEN-2:0], bit_in};
    end
endmodule

// File: rtl/spg_lag_correlator.sv
`timescale 1ns/1ps
module spg_lag_correlator #(
    parameter int PAST_BITS = 10,
    parameter int NET_W     = 5
) (
    input  logic [PAST_BITS:0]        hist,     // [0] = decision, [k] = k older
    input  logic [PAST_BITS-1:0]      lag_sel,
    output logic signed [NET_W-1:0]   net
);
    logic [PAST_BITS-1:0] agree;

    genvar k;
    generate
        for (k = 0; k < PAST_BITS; k++) begin : g_lag
            assign agree[k] = ~(hist[0] ^ hist[k+1]);
        end
    endgenerate

    always_comb begin
        logic [NET_W-1:0] n_up;
        logic [NET_W-1:0] n_dn;
        n_up = NET_W'($countones(lag_sel & agree));
        n_dn = NET_W'($countones(lag_sel & ~agree));
        net  = $signed(n_up - n_dn);
    end
endmodule

// File: rtl/spg_sat_accum.sv
`timescale 1ns/1ps
module spg_sat_accum #(
    parameter int ACC_W = 9,
    parameter int NET_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     add_en,
    input  logic signed [NET_W-1:0]  net,
    output logic signed [ACC_W-1:0]  acc,
    output logic [ACC_W-1:0]         mag
);
    localparam logic signed [ACC_W:0]   WIDE_MAX = (ACC_W+1)'(2**(ACC_W-1) - 1);
    localparam logic signed [ACC_W:0]   WIDE_MIN = (ACC_W+1)'(-(2**(ACC_W-1)));
    localparam logic signed [ACC_W-1:0] ACC_MAX  = ACC_W'(2**(ACC_W-1) - 1);
    localparam logic signed [ACC_W-1:0] ACC_MIN  = ACC_W'(-(2**(ACC_W-1)));

    logic signed [ACC_W:0]   wide;
    logic signed [ACC_W-1:0] sum_sat;

    always_comb begin
        wide = (ACC_W+1)'(acc) + (ACC_W+1)'(net);
        if (wide > WIDE_MAX)
            sum_sat = ACC_MAX;
        else if (wide < WIDE_MIN)
            sum_sat = ACC_MIN;
        else
            sum_sat = wide[ACC_W-1:0];
        // most negative value reads back as 2**(ACC_W-1) unsigned
        mag = sum_sat[ACC_W-1] ? $unsigned(-sum_sat) : $unsigned(sum_sat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (add_en)
            acc <= sum_sat;
    end

    // R5: pinned at the top rail
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && add_en && acc == ACC_MAX && net > 0) |=> (acc == ACC_MAX));
    // R5: pinned at the bottom rail
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && add_en && acc == ACC_MIN && net < 0) |=> (acc == ACC_MIN));
    // R7: a clear always empties the accumulator
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
endmodule

// File: rtl/spectral_gate.sv
`timescale 1ns/1ps
module spectral_gate #(
    parameter int PAST_BITS   = 10,
    parameter int FUTURE_BITS = 3,
    parameter int ACC_W       = 9,
    parameter int EVAL_LEN    = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_in,
    input  logic                  bit_valid,
    input  logic                  snap_en,
    input  logic                  acc_clr,
    input  logic [PAST_BITS-1:0]  lag_sel,
    input  logic [ACC_W-1:0]      thresh,
    output logic                  adapt_en,
    output logic [ACC_W-1:0]      acc_out
);
    import spgate_pkg::*;

    localparam int WIN_LEN = PAST_BITS + FUTURE_BITS + 1;
    localparam int FILL_W  = $clog2(WIN_LEN + 1);
    localparam int CNT_W   = (EVAL_LEN > 1) ? $clog2(EVAL_LEN) : 1;
    localparam int NET_W   = $clog2(PAST_BITS + 1) + 1;

    gate_state_e                 state, state_nx;
    logic [FILL_W-1:0]           fill_cnt;
    logic [CNT_W-1:0]            snap_cnt;
    logic [WIN_LEN-1:0]          win;
    logic signed [NET_W-1:0]     net;
    logic signed [ACC_W-1:0]     acc_s;
    logic [ACC_W-1:0]            mag;
    logic                        take, last, boundary;

    spg_snap_window #(.PAST_BITS(PAST_BITS), .FUTURE_BITS(FUTURE_BITS)) u_window (
        .clk(clk), .rst_n(rst_n), .shift_en(bit_valid), .bit_in(bit_in), .win(win)
    );

    spg_lag_correlator #(.PAST_BITS(PAST_BITS), .NET_W(NET_W)) u_corr (
        .hist(win[WIN_LEN-1:FUTURE_BITS]), .lag_sel(lag_sel), .net(net)
    );

    spg_sat_accum #(.ACC_W(ACC_W), .NET_W(NET_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr | boundary), .add_en(take),
        .net(net), .acc(acc_s), .mag(mag)
    );

    assign take     = (state == ST_TRACK) && snap_en && !acc_clr;
    assign last     = (snap_cnt == CNT_W'(EVAL_LEN - 1));
    assign boundary = take && last;
    assign acc_out  = $unsigned(acc_s);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL:  if (bit_valid && fill_cnt == FILL_W'(WIN_LEN - 1)) state_nx = ST_TRACK;
            ST_TRACK: state_nx = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            snap_cnt <= '0;
            adapt_en <= 1'b0;
        end else begin
            if (state == ST_FILL && bit_valid)
                fill_cnt <= fill_cnt + FILL_W'(1);
            if (acc_clr || boundary)
                snap_cnt <= '0;
            else if (take)
                snap_cnt <= snap_cnt + CNT_W'(1);
            if (boundary)
                adapt_en <= (mag <= thresh);
        end
    end

    // R2: nothing accumulates while the window fills
    p_fill_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> (acc_s == '0));
    // R6: enable moves only on an accepted snapshot
    p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(snap_en && !acc_clr) |=> $stable(adapt_en));
    // R6: window end restarts the sum
    p_window_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (acc_s == '0));
    // R7: clear beats a coincident snapshot
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr && snap_en) |=> ($stable(adapt_en) && acc_s == '0));
endmodule

// File: tb/spectral_gate_tb.sv
`timescale 1ns/1ps
module spectral_gate_tb;
    localparam int PAST = 10;
    localparam int FUT  = 3;
    localparam int AW   = 9;
    localparam int EVAL = 64;
    localparam int WL   = PAST + FUT + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_in = 1'b0, bit_valid = 1'b0, snap_en = 1'b0, acc_clr = 1'b0;
    logic [PAST-1:0] lag_sel = '0;
    logic [AW-1:0]   thresh  = '0;
    logic            adapt_en;
    logic [AW-1:0]   acc_out;

    int checks = 0, errors = 0;
    logic [WL-1:0] mwin;
    int  mfill, macc, mcnt;
    bit  mfull, men;
    logic [6:0] prbs;
    logic alt;

    always #2.5 clk = ~clk;

    spectral_gate #(.PAST_BITS(PAST), .FUTURE_BITS(FUT), .ACC_W(AW), .EVAL_LEN(EVAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .snap_en(snap_en), .acc_clr(acc_clr), .lag_sel(lag_sel), .thresh(thresh),
        .adapt_en(adapt_en), .acc_out(acc_out)
    );

    function automatic int sat(int v);
        if (v > 2**(AW-1) - 1) return 2**(AW-1) - 1;
        if (v < -(2**(AW-1)))  return -(2**(AW-1));
        return v;
    endfunction

    function automatic int absv(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int mnet(logic [WL-1:0] w, logic [PAST-1:0] sel);
        int n = 0;
        for (int k = 0; k < PAST; k++)
            if (sel[k]) n += (w[FUT] == w[FUT+k+1]) ? 1 : -1;
        return n;
    endfunction

    function automatic logic next_prbs();
        logic nb;
        nb   = prbs[6] ^ prbs[5];
        prbs = {prbs[5:0], nb};
        return nb;
    endfunction

    task automatic chk(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(int'($signed(acc_out)), macc, {tag, " acc"});
        chk(int'(adapt_en), int'(men), {tag, " enable"});
    endtask

    task automatic model_edge(logic b, logic v, logic s, logic c);
        if (c) begin
            macc = 0; mcnt = 0;
        end else if (mfull && s) begin
            int t;
            t = sat(macc + mnet(mwin, lag_sel));
            if (mcnt == EVAL - 1) begin
                men  = (absv(t) <= int'(thresh));
                macc = 0; mcnt = 0;
            end else begin
                macc = t; mcnt++;
            end
        end
        if (v) begin
            mwin = {mwin[WL-2:0], b};
            if (!mfull) begin
                mfill++;
                if (mfill == WL) mfull = 1'b1;
            end
        end
    endtask

    task automatic step(logic b, logic v, logic s, logic c, string tag);
        @(negedge clk);
        bit_in = b; bit_valid = v; snap_en = s; acc_clr = c;
        @(posedge clk);
        model_edge(b, v, s, c);
        #1;
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mwin = '0; mfill = 0; mfull = 1'b0; macc = 0; mcnt = 0; men = 1'b0;
        prbs = 7'h5A; alt = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk(int'(adapt_en), 0, "R1 reset enable");
        chk(int'(acc_out), 0, "R1 reset acc");

        // R2 / R9: fill with snapshots that must be ignored
        lag_sel = '1; thresh = 9'd100;
        for (int i = 0; i < WL - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
        chk(int'(acc_out), 0, "R2 fill edge snapshot ignored");

        // R5 / R8: static ones saturate and freeze adaptation
        for (int i = 0; i < EVAL - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R5");
        chk(int'($signed(acc_out)), 255, "R5 saturate high");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R6");
        chk(int'(adapt_en), 0, "R8 static freezes");
        chk(int'(acc_out), 0, "R6 window clear");

        // R8: pseudo-random data re-enables
        for (int i = 0; i < WL; i++) step(next_prbs(), 1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R7");
        for (int i = 0; i < EVAL; i++) step(next_prbs(), 1'b1, 1'b1, 1'b0, "R8");
        chk(int'(adapt_en), 1, "R8 random enables");

        // R7: clear on the closing snapshot
        for (int i = 0; i < EVAL - 1; i++) step(next_prbs(), 1'b1, 1'b1, 1'b0, "R3");
        step(next_prbs(), 1'b1, 1'b1, 1'b1, "R7");
        chk(int'(adapt_en), 1, "R7 enable unchanged");
        chk(int'(acc_out), 0, "R7 clear wins");

        // R6: threshold edge with lag 1 on alternating data (-1 per snapshot)
        lag_sel = 10'h001; thresh = 9'd64;
        for (int i = 0; i < WL; i++) begin step(alt, 1'b1, 1'b0, 1'b0, "R9"); alt = ~alt; end
        step(1'b0, 1'b0, 1'b0, 1'b1, "R7");
        for (int i = 0; i < EVAL; i++) begin step(alt, 1'b1, 1'b1, 1'b0, "R3"); alt = ~alt; end
        chk(int'(adapt_en), 1, "R6 magnitude equal to threshold");
        thresh = 9'd63;
        for (int i = 0; i < EVAL; i++) begin step(alt, 1'b1, 1'b1, 1'b0, "R3"); alt = ~alt; end
        chk(int'(adapt_en), 0, "R6 magnitude above threshold");

        // R5: odd lags give -5 per snapshot, rail at -256
        lag_sel = 10'h155; thresh = 9'd256;
        step(1'b0, 1'b0, 1'b0, 1'b1, "R7");
        for (int i = 0; i < EVAL - 1; i++) begin step(alt, 1'b1, 1'b1, 1'b0, "R5"); alt = ~alt; end
        chk(int'($signed(acc_out)), -256, "R5 saturate low");
        step(alt, 1'b1, 1'b1, 1'b0, "R5"); alt = ~alt;
        chk(int'(adapt_en), 1, "R5 magnitude 256 within threshold");

        // R3 / R4: every lag mask, shift and snapshot on the same edge
        for (int m = 0; m < 2**PAST; m++) begin
            lag_sel = PAST'(m);
            step(1'b0, 1'b0, 1'b0, 1'b1, "R7");
            step(next_prbs(), 1'b1, 1'b1, 1'b0, "R3 R4");
        end

        // mixed sweep
        for (int i = 0; i < 4000; i++) begin
            if (i % 97 == 0) begin
                lag_sel = PAST'($urandom);
                thresh  = AW'($urandom % 200);
            end
            step(1'($urandom % 2), ($urandom % 4) != 0, 1'($urandom % 2),
                 ($urandom % 200) == 0, "R3 R5 R6 R7 R9 sweep");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule